// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Capture Front End

This block takes 4:2:2 YCbCr video from a 16-pin parallel port and turns it into one output beat per pixel: a luma sample, the most recent Cb and Cr, and a one-cycle valid strobe. It runs on the double-rate pixel clock `clk2`. A half-rate phase signal, `phase_clk`, marks which `clk2` edges carry data in the wide mode. The wide mode puts luma on the upper byte and multiplexed chroma on the lower byte. The narrow mode sends every component through the upper byte, one after another.

Whether a sample is active depends on a blanking signal. That signal either comes in on `blank_in`, sampled together with the data, or is produced on `blank_out` from a window request given by the timing generator. When the block produces it, `blank_sel` picks one of two alignments between the fall of `blank_out` and the first captured sample. Luma is floored at black level. Chroma is passed through without change.

The output is a stream with a valid strobe only. Video cannot be stalled, so there is no ready signal and no back-pressure. The consumer must accept every beat in the cycle where `px_valid` is high, and the `px_*` data buses hold their values only until the next capture.

Top module: `ycc422_capture`

## Requirements
- R1: After a synchronous reset, `px_valid` is low, `blank_out` is high (blanking), and the chroma sequence waits for Cb.
- R2: Wide mode (`mode_wide`=1). Capture happens only at `clk2` edges where `phase_clk` is low. At each such active edge, `pix_in[15:8]` is luma and `pix_in[7:0]` is chroma, alternating Cb then Cr. `px_valid` is high for the one cycle after each such edge.
- R3: Narrow mode (`mode_wide`=0). Capture happens at every `clk2` edge from `pix_in[15:8]`, in the order Cb, Y, Cr, Y. `px_valid` follows only the Y edges, so it is never high in two consecutive cycles. `pix_in[7:0]` has no effect.
- R4: Every capture edge that is not active resets the sequence to Cb and sets the held Cb and Cr to 128. Each pixel carries the last Cb and Cr captured at or before its Y edge. As a result, the first pixel of every line has Cr = 128 and Cb equal to that line's first sample.
- R5: Luma below 16 is output as 16. Luma from 16 to 255 is output unchanged.
- R6: Cb and Cr are output unchanged over the whole range 0 to 255.
- R7: With `blank_dir_out`=0, a capture edge is active exactly when `blank_in` is low at that same edge. Data at inactive edges never appears on the output.
- R8: `blank_out` takes the value of `!win_req` only at `clk2` edges where `mode_wide`=0 or `phase_clk`=1. At all other edges it holds its value.
- R9: With `blank_dir_out`=1 and `blank_sel`=1, the first capture edge after `blank_out` falls is active. With `blank_sel`=0, the second capture edge after the fall is the first active one. The end of the active run follows the same offset after `blank_out` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_wide | input | 1 | 1: two-lane 16-bit layout; 0: single-lane 8-bit layout |
| phase_clk | input | 1 | Half-rate phase; wide mode captures when it is low |
| blank_dir_out | input | 1 | 1: active span taken from `blank_out`; 0: from `blank_in` |
| blank_sel | input | 1 | 1: first sample in the same pixel slot as the fall of `blank_out`; 0: one slot later |
| blank_in | input | 1 | External blanking, high = blank, sampled with the data |
| win_req | input | 1 | Active-window request from the timing generator |
| pix_in | input | 16 | Pixel port; upper byte luma or all components, lower byte chroma |
| blank_out | output | 1 | Generated blanking, high = blank |
| px_valid | output | 1 | One-cycle strobe per output pixel |
| px_y | output | 8 | Floored luma |
| px_cb | output | 8 | Held Cb for the pixel |
| px_cr | output | 8 | Held Cr for the pixel |

## Verification
A chroma sequence state that is out of step shows up as Cb and Cr swapped, or as a stale Cr other than 128. This is visible on the first `px_valid` of the next line, at most one pixel after the fault. A wrong capture-slot or blanking alignment shifts every sample of a line by one position, so the first beat already carries the wrong luma and the line's beat count is off. The bench sweeps both layouts and all three blanking configurations, plus a full 0 to 255 luma ramp. It predicts every beat from the per-line sample formulas.

// File: rtl/ycc_cap_pkg.sv
`timescale 1ns/1ps
package ycc_cap_pkg;
  localparam int unsigned COMP_W = 8;
  typedef logic [COMP_W-1:0] comp_t;

  // Position within the single-lane Cb, Y, Cr, Y' cycle
  typedef enum logic [1:0] {
    SEQ_CB  = 2'd0,
    SEQ_YA  = 2'd1,
    SEQ_CR  = 2'd2,
    SEQ_YB  = 2'd3
  } nseq_e;

  function automatic comp_t luma_floor(comp_t v, comp_t lo);
    return (v < lo) ? lo : v;
  endfunction
endpackage

// File: rtl/ycc_slot_ctl.sv
`timescale 1ns/1ps
module ycc_slot_ctl (
  input  logic clk2,
  input  logic rst,
  input  logic mode_wide,
  input  logic phase_clk,
  input  logic blank_dir_out,
  input  logic blank_sel,
  input  logic blank_in,
  input  logic win_req,
  output logic slot,
  output logic act,
  output logic blank_out
);
  logic upd;
  logic blank_q;
  logic blank_d;

  // Capture edges and output-update edges
  assign slot = mode_wide ? ~phase_clk : 1'b1;
  assign upd  = mode_wide ?  phase_clk : 1'b1;

  always_ff @(posedge clk2) begin
    if (rst) begin
      blank_q <= 1'b1;
      blank_d <= 1'b1;
    end else begin
      if (upd)  blank_q <= ~win_req;
      if (slot) blank_d <= blank_q;
    end
  end

  assign act       = blank_dir_out ? ~(blank_sel ? blank_q : blank_d) : ~blank_in;
  assign blank_out = blank_q;

  // R1: blanking asserted out of reset
  a_r1_blank_reset: assert property (@(posedge clk2) rst |=> blank_out);
  // R8: no change except on update edges
  a_r8_hold: assert property (@(posedge clk2) disable iff (rst)
    !upd |=> $stable(blank_out));
endmodule

// File: rtl/ycc_lane_demux.sv
`timescale 1ns/1ps
module ycc_lane_demux
  import ycc_cap_pkg::*;
#(
  parameter comp_t Y_FLOOR = comp_t'(16),
  parameter comp_t C_ZERO  = comp_t'(128)
) (
  input  logic  clk2,
  input  logic  rst,
  input  logic  mode_wide,
  input  logic  slot,
  input  logic  act,
  input  comp_t lane_hi,
  input  comp_t lane_lo,
  output logic  vld,
  output comp_t y_q,
  output comp_t cb_q,
  output comp_t cr_q
);
  nseq_e seq;
  logic  wide_cr;

  always_ff @(posedge clk2) begin
    if (rst) begin
      seq     <= SEQ_CB;
      wide_cr <= 1'b0;
      vld     <= 1'b0;
      y_q     <= Y_FLOOR;
      cb_q    <= C_ZERO;
      cr_q    <= C_ZERO;
    end else begin
      vld <= 1'b0;
      if (slot) begin
        if (!act) begin
          seq     <= SEQ_CB;
          wide_cr <= 1'b0;
          cb_q    <= C_ZERO;
          cr_q    <= C_ZERO;
        end else if (mode_wide) begin
          y_q <= luma_floor(lane_hi, Y_FLOOR);
          vld <= 1'b1;
          if (wide_cr) cr_q <= lane_lo;
          else         cb_q <= lane_lo;
          wide_cr <= ~wide_cr;
        end else begin
          unique case (seq)
            SEQ_CB: cb_q <= lane_hi;
            SEQ_CR: cr_q <= lane_hi;
            default: begin
              y_q <= luma_floor(lane_hi, Y_FLOOR);
              vld <= 1'b1;
            end
          endcase
          seq <= nseq_e'(seq + 2'd1);
        end
      end
    end
  end

  // R1: no output beat right after reset
  a_r1_valid_reset: assert property (@(posedge clk2) rst |=> !vld);
  // R5: luma never below black floor on a beat
  a_r5_floor: assert property (@(posedge clk2) disable iff (rst)
    vld |-> (y_q >= Y_FLOOR));
  // R3: narrow mode never emits two beats back to back
  a_r3_no_back_to_back: assert property (@(posedge clk2) disable iff (rst)
    (vld && !mode_wide) |=> !vld);
endmodule

// File: rtl/ycc422_capture.sv
`timescale 1ns/1ps
module ycc422_capture
  import ycc_cap_pkg::*;
#(
  parameter int unsigned Y_FLOOR = 16,
  parameter int unsigned C_ZERO  = 128
) (
  input  logic                clk2,
  input  logic                rst,
  input  logic                mode_wide,
  input  logic                phase_clk,
  input  logic                blank_dir_out,
  input  logic                blank_sel,
  input  logic                blank_in,
  input  logic                win_req,
  input  logic [2*COMP_W-1:0] pix_in,
  output logic                blank_out,
  output logic                px_valid,
  output logic [COMP_W-1:0]   px_y,
  output logic [COMP_W-1:0]   px_cb,
  output logic [COMP_W-1:0]   px_cr
);
  localparam int unsigned PIN_W   = 2 * COMP_W;
  localparam comp_t       FLOOR_C = comp_t'(Y_FLOOR);
  localparam comp_t       ZERO_C  = comp_t'(C_ZERO);

  logic  slot;
  logic  act;
  comp_t lane_hi;
  comp_t lane_lo;

  assign lane_hi = pix_in[PIN_W-1:COMP_W];
  assign lane_lo = pix_in[COMP_W-1:0];

  ycc_slot_ctl u_slot (
    .clk2          (clk2),
    .rst           (rst),
    .mode_wide     (mode_wide),
    .phase_clk     (phase_clk),
    .blank_dir_out (blank_dir_out),
    .blank_sel     (blank_sel),
    .blank_in      (blank_in),
    .win_req       (win_req),
    .slot          (slot),
    .act           (act),
    .blank_out     (blank_out)
  );

  ycc_lane_demux #(
    .Y_FLOOR (FLOOR_C),
    .C_ZERO  (ZERO_C)
  ) u_demux (
    .clk2      (clk2),
    .rst       (rst),
    .mode_wide (mode_wide),
    .slot      (slot),
    .act       (act),
    .lane_hi   (lane_hi),
    .lane_lo   (lane_lo),
    .vld       (px_valid),
    .y_q       (px_y),
    .cb_q      (px_cb),
    .cr_q      (px_cr)
  );

  // R2: in wide mode a beat only follows a phase-low edge
  a_r2_wide_phase: assert property (@(posedge clk2) disable iff (rst)
    (px_valid && $past(mode_wide)) |-> !$past(phase_clk));
endmodule

// File: tb/ycc422_capture_test.sv
`timescale 1ns/1ps
module ycc422_capture_test;
  logic        clk2 = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wide = 1'b0;
  logic        phase_clk = 1'b0;
  logic        blank_dir_out = 1'b0;
  logic        blank_sel = 1'b0;
  logic        blank_in = 1'b1;
  logic        win_req = 1'b0;
  logic [15:0] pix_in = 16'h0;
  logic        blank_out, px_valid;
  logic [7:0]  px_y, px_cb, px_cr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] got_y [0:511];
  logic [7:0] got_cb[0:511];
  logic [7:0] got_cr[0:511];
  int got_n = 0;

  ycc422_capture uut (
    .clk2(clk2), .rst(rst), .mode_wide(mode_wide), .phase_clk(phase_clk),
    .blank_dir_out(blank_dir_out), .blank_sel(blank_sel), .blank_in(blank_in),
    .win_req(win_req), .pix_in(pix_in), .blank_out(blank_out),
    .px_valid(px_valid), .px_y(px_y), .px_cb(px_cb), .px_cr(px_cr)
  );

  always #2 clk2 = ~clk2;

  always @(negedge clk2) begin
    if (!rst && px_valid && got_n < 512) begin
      got_y[got_n]  = px_y;
      got_cb[got_n] = px_cb;
      got_cr[got_n] = px_cr;
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] yv(int i, int seed);
    if (seed == 0) return 8'(i);
    return 8'((i * 29 + seed * 7) & 255);
  endfunction
  function automatic logic [7:0] cbv(int k, int seed);
    return 8'((k * 61 + seed * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] crv(int k, int seed);
    return 8'((k * 43 + seed * 3 + 200) & 255);
  endfunction

  // One pixel slot: wide = phase-high edge then phase-low edge; narrow = one edge
  task automatic step(input bit wide, input bit win, input logic [15:0] d, input bit bl);
    if (wide) begin
      phase_clk = 1'b1; win_req = win; pix_in = ~d; blank_in = ~bl;
      @(posedge clk2); @(negedge clk2);
      phase_clk = 1'b0; pix_in = d; blank_in = bl;
      @(posedge clk2); @(negedge clk2);
    end else begin
      phase_clk = ~phase_clk; win_req = win; pix_in = d; blank_in = bl;
      @(posedge clk2); @(negedge clk2);
    end
  endtask

  task automatic run_line(input bit wide, input bit dout, input bit sel,
                          input int npix, input int seed);
    int nsl = wide ? npix : 2 * npix;
    int lead = 3;
    int off = dout ? ((wide ? 0 : 1) + (sel ? 0 : 1)) : 0;
    mode_wide = wide; blank_dir_out = dout; blank_sel = sel;
    got_n = 0;
    for (int s = 0; s < lead + nsl + off + 3; s++) begin
      bit win = dout && (s >= lead) && (s < lead + nsl);
      int j = s - lead - off;
      logic [15:0] d;
      bit bl;
      if (j >= 0 && j < nsl) begin
        if (wide) begin
          d[15:8] = yv(j, seed);
          d[7:0]  = (j % 2) ? crv(j / 2, seed) : cbv(j / 2, seed);
        end else begin
          unique case (j % 4)
            0: d[15:8] = cbv(j / 4, seed);
            1: d[15:8] = yv(2 * (j / 4), seed);
            2: d[15:8] = crv(j / 4, seed);
            default: d[15:8] = yv(2 * (j / 4) + 1, seed);
          endcase
          d[7:0] = 8'(j * 97 + 33); // R3: lower lane junk, must be ignored
        end
        bl = dout ? (j % 3 == 1) : 1'b0; // R7/R9: blank_in junk when not used
      end else begin
        d  = 16'(16'hA55A ^ 16'(s * 4421));
        bl = dout ? (s % 2 == 0) : 1'b1;
      end
      step(wide, win, d, bl);
      if (dout) chk(blank_out == !win, "R8 blank_out follows window", int'(blank_out), int'(!win));
    end
    chk(got_n == npix, wide ? "R2 beat count" : "R3 beat count", got_n, npix);
    for (int i = 0; i < npix && i < got_n; i++) begin
      int ey  = (int'(yv(i, seed)) < 16) ? 16 : int'(yv(i, seed));
      int ecb = int'(cbv(i / 2, seed));
      int ecr = (i % 2) ? int'(crv(i / 2, seed)) : ((i == 0) ? 128 : int'(crv(i / 2 - 1, seed)));
      chk(got_y[i] == 8'(ey), dout ? "R9/R5 luma" : "R7/R5 luma", int'(got_y[i]), ey);
      chk(got_cb[i] == 8'(ecb), "R6/R4 cb", int'(got_cb[i]), ecb);
      chk(got_cr[i] == 8'(ecr), "R6/R4 cr", int'(got_cr[i]), ecr);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk2); @(negedge clk2); @(negedge clk2);
    rst = 1'b0;
    @(negedge clk2);
    // R1 reset state
    chk(px_valid == 1'b0, "R1 valid after reset", int'(px_valid), 0);
    chk(blank_out == 1'b1, "R1 blank after reset", int'(blank_out), 1);
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 3; c++)
        for (int sd = 1; sd < 3; sd++)
          run_line(w[0], c != 0, c == 2, 8, sd); // back-to-back lines: R4 restart
    run_line(1'b1, 1'b0, 1'b0, 256, 0); // R5 full luma ramp, wide
    run_line(1'b0, 1'b1, 1'b1, 256, 0); // R5 full luma ramp, narrow
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule